// File: doc/BRIEF.md
# BCD Time-of-Day Register File with Transfer Inhibit

This block is a byte-wide, memory-mapped real-time clock. A private time-of-day counter holds seconds, minutes, hours, weekday, date, month, year-in-century and century, all in BCD. It advances once for each pulse on a one-second tick input that comes from an external prescaler. Software never reads the counter directly. It reads a shadow bank that is refreshed from the counter in a single clock cycle after each tick. Every register sits at its own offset, so an access needs only one address and no index/data pair.

A control register carries an inhibit bit, a 24-hour flag and an active-low stop bit. While inhibit is set, the shadow bank is frozen so that a multi-byte read stays coherent, and the counter keeps counting. Time fields written during inhibit land in the shadow bank and are marked dirty. When inhibit is cleared, only the dirty fields are loaded into the counter. Later ticks then refresh the shadow bank again.

A four-state sequencer sets the ordering. The states are RUN (live), XFER (one-cycle refresh), HOLD (frozen) and LOAD (one-cycle commit). The transitions are:
- RUN→XFER on an accepted tick.
- RUN→HOLD when inhibit is seen without a tick.
- XFER→HOLD when inhibit is set.
- XFER→RUN when inhibit is clear.
- HOLD→LOAD when inhibit is cleared.
- LOAD→RUN unconditionally.

Top module: `rtc_regfile`

## Requirements
- R1: After reset the bank reads 00 seconds, 00 minutes, 00 hours, weekday 01, date 01, month 01, year 00 and century 20 (BCD). The control register reads 0x03 and `xfer_busy` is low.
- R2: Offsets 0 to 7 read seconds, minutes, hours, weekday, date, month, year and century. Offset 0xE is control: bit 3 is inhibit, bit 1 is the 24-hour flag and bit 0 is run (0 stops). Control bits 7:4 and 2 read 0, and every other offset reads 0x00. The read data is combinational from the address.
- R3: A tick sampled at clock edge E advances the counter at E. The shadow bank shows the new value from edge E+1.
- R4: Seconds and minutes wrap 59→00 and hours wrap 23→00, each carrying into the next field. The weekday runs 01 to 07 and then wraps to 01 on a day carry.
- R5: The date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months. February wraps after 29 in a leap year and after 28 otherwise. A leap year is one where the year-in-century is a nonzero multiple of 4, or the year-in-century is 00 and the century is a multiple of 4.
- R6: Month wraps 12→01 and carries into the year. Year wraps 99→00 and carries into the century. Century wraps 99→00.
- R7: While inhibit is 1 the shadow bank does not change except through software writes, and the counter keeps advancing on ticks.
- R8: Writes to offsets 0 to 7 while inhibit is 0 have no effect.
- R9: When inhibit returns to 0, exactly the fields written during inhibit are loaded into the counter. The other fields keep their counted values.
- R10: If inhibit is set in the same cycle as an accepted tick, that refresh still completes and then the bank freezes.
- R11: With run = 0, ticks neither advance the counter nor refresh the bank.
- R12: `xfer_busy` is high for exactly one cycle per accepted tick: the cycle after the tick edge.
- R13: A tick that arrives during the commit cycle is held and accepted one cycle later, not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1s | input | 1 | One-cycle pulse per second from prescaler |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| xfer_busy | output | 1 | High during the shadow refresh cycle |

## Verification
Read data depends only on the current address and shadow state, so it is due in the same cycle the address is driven. A tick sampled at one edge raises `xfer_busy` after that edge and updates the shadow bank at the next edge. A release of inhibit commits dirty fields two edges after the control write, and a tick that falls in the commit cycle is seen one edge late. The bench drives inputs just after rising edges and updates a behavioural calendar model at each rising edge. It compares `xfer_busy` and `bus_rdata` against that model at every falling edge, and adds directed reads with hand-computed values once enough edges have passed for each result to settle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NFLD  = 8;
    localparam int F_SEC = 0;
    localparam int F_MIN = 1;
    localparam int F_HR  = 2;
    localparam int F_WDY = 3;
    localparam int F_DAT = 4;
    localparam int F_MON = 5;
    localparam int F_YR  = 6;
    localparam int F_CEN = 7;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_XFER = 2'd1,
        ST_HOLD = 2'd2,
        ST_LOAD = 2'd3
    } xfer_st_e;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
        return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
    endfunction

    // last valid date of a month, BCD, with leap rule from year and century
    function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                  input logic [7:0] yr,
                                                  input logic [7:0] cen);
        logic [7:0] yb;
        logic [7:0] cb;
        logic       leap;
        yb   = bcd_to_bin(yr);
        cb   = bcd_to_bin(cen);
        leap = (yb != 8'd0) ? (yb[1:0] == 2'b00) : (cb[1:0] == 2'b00);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic logic [7:0] field_reset(input int idx, input logic [7:0] cen);
        if (idx == F_WDY || idx == F_DAT || idx == F_MON) return 8'h01;
        if (idx == F_CEN) return cen;
        return 8'h00;
    endfunction

endpackage

// File: rtl/rtc_tod_counter.sv
module rtc_tod_counter
    import rtc_pkg::*;
#(
    parameter logic [7:0] RST_CEN = 8'h20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adv,
    input  logic [NFLD-1:0]       load_en,
    input  logic [NFLD-1:0][7:0]  load_val,
    output logic [NFLD-1:0][7:0]  cnt
);

    logic [7:0] cnt_q   [NFLD];
    logic [7:0] cnt_nxt [NFLD];
    logic       w_sec, w_min, w_hr, w_dat, w_mon, w_yr;
    logic       c_min, c_hr, c_day, c_mon, c_yr, c_cen;

    always_comb begin
        w_sec = (cnt_q[F_SEC] == 8'h59);
        w_min = (cnt_q[F_MIN] == 8'h59);
        w_hr  = (cnt_q[F_HR]  == 8'h23);
        w_dat = (cnt_q[F_DAT] == month_last_day(cnt_q[F_MON], cnt_q[F_YR], cnt_q[F_CEN]));
        w_mon = (cnt_q[F_MON] == 8'h12);
        w_yr  = (cnt_q[F_YR]  == 8'h99);
        c_min = w_sec;
        c_hr  = c_min & w_min;
        c_day = c_hr  & w_hr;
        c_mon = c_day & w_dat;
        c_yr  = c_mon & w_mon;
        c_cen = c_yr  & w_yr;

        for (int i = 0; i < NFLD; i++) cnt_nxt[i] = cnt_q[i];
        cnt_nxt[F_SEC] = w_sec ? 8'h00 : bcd_inc(cnt_q[F_SEC]);
        if (c_min) cnt_nxt[F_MIN] = w_min ? 8'h00 : bcd_inc(cnt_q[F_MIN]);
        if (c_hr)  cnt_nxt[F_HR]  = w_hr  ? 8'h00 : bcd_inc(cnt_q[F_HR]);
        if (c_day) begin
            cnt_nxt[F_WDY] = (cnt_q[F_WDY] == 8'h07) ? 8'h01 : bcd_inc(cnt_q[F_WDY]);
            cnt_nxt[F_DAT] = w_dat ? 8'h01 : bcd_inc(cnt_q[F_DAT]);
        end
        if (c_mon) cnt_nxt[F_MON] = w_mon ? 8'h01 : bcd_inc(cnt_q[F_MON]);
        if (c_yr)  cnt_nxt[F_YR]  = w_yr  ? 8'h00 : bcd_inc(cnt_q[F_YR]);
        if (c_cen) cnt_nxt[F_CEN] = (cnt_q[F_CEN] == 8'h99) ? 8'h00 : bcd_inc(cnt_q[F_CEN]);
    end

    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt_q[g] <= field_reset(g, RST_CEN);
            else if (load_en[g])   cnt_q[g] <= load_val[g];
            else if (adv)          cnt_q[g] <= cnt_nxt[g];
        end
        assign cnt[g] = cnt_q[g];
    end

    p_sec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && load_en == '0 && cnt_q[F_SEC] == 8'h59) |=> (cnt_q[F_SEC] == 8'h00));

    p_feb_common_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && load_en == '0 && cnt_q[F_SEC] == 8'h59 && cnt_q[F_MIN] == 8'h59 &&
         cnt_q[F_HR] == 8'h23 && cnt_q[F_DAT] == 8'h28 && cnt_q[F_MON] == 8'h02 &&
         cnt_q[F_YR] == 8'h23) |=> (cnt_q[F_DAT] == 8'h01 && cnt_q[F_MON] == 8'h03));

endmodule

// File: rtl/rtc_xfer_fsm.sv
module rtc_xfer_fsm
    import rtc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     adv,
    input  logic     inhibit,
    output xfer_st_e st_o,
    output logic     copy_o,
    output logic     commit_o
);

    xfer_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (adv) state_d = ST_XFER;
                     else if (inhibit) state_d = ST_HOLD;
            ST_XFER: state_d = inhibit ? ST_HOLD : ST_RUN;
            ST_HOLD: if (!inhibit) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        st_o     = state_q;
        copy_o   = (state_q == ST_XFER);
        commit_o = (state_q == ST_LOAD);
    end

    p_busy_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER) |=> (state_q != ST_XFER));

    p_xfer_then_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && inhibit) |=> (state_q == ST_HOLD));

    p_commit_then_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> (state_q == ST_RUN));

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int         ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFF = 4'hE,
    parameter logic [7:0] RST_CEN  = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1s,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              xfer_busy
);

    localparam int FLD_AW = $clog2(NFLD);

    logic                 inh_q, h24_q, run_q, pend_q;
    logic [7:0]           sh_q [NFLD];
    logic [NFLD-1:0]      dirty_q;
    logic [NFLD-1:0][7:0] sh_flat;
    logic [NFLD-1:0][7:0] cnt;
    logic                 in_fld, fld_wr, ctrl_wr;
    logic                 adv_req, adv, copy, commit;
    xfer_st_e             st;

    assign in_fld  = (bus_addr < ADDR_W'(NFLD));
    assign fld_wr  = bus_wr && in_fld && inh_q;
    assign ctrl_wr = bus_wr && (bus_addr == CTRL_OFF);
    assign adv_req = tick_1s | pend_q;
    assign adv     = adv_req && run_q && (st != ST_LOAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inh_q  <= 1'b0;
            h24_q  <= 1'b1;
            run_q  <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            pend_q <= adv_req && (st == ST_LOAD);
            if (ctrl_wr) begin
                inh_q <= bus_wdata[3];
                h24_q <= bus_wdata[1];
                run_q <= bus_wdata[0];
            end
        end
    end

    for (genvar g = 0; g < NFLD; g++) begin : g_sh
        logic hit;
        assign hit = fld_wr && (bus_addr[FLD_AW-1:0] == FLD_AW'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q[g]    <= field_reset(g, RST_CEN);
                dirty_q[g] <= 1'b0;
            end else begin
                if (hit)                        sh_q[g] <= bus_wdata;
                else if (copy && !dirty_q[g])   sh_q[g] <= cnt[g];
                if (hit)                        dirty_q[g] <= 1'b1;
                else if (commit)                dirty_q[g] <= 1'b0;
            end
        end
        assign sh_flat[g] = sh_q[g];
    end

    rtc_xfer_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .inhibit  (inh_q),
        .st_o     (st),
        .copy_o   (copy),
        .commit_o (commit)
    );

    rtc_tod_counter #(.RST_CEN(RST_CEN)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .load_en  (commit ? dirty_q : '0),
        .load_val (sh_flat),
        .cnt      (cnt)
    );

    always_comb begin
        if (in_fld)                    bus_rdata = sh_q[bus_addr[FLD_AW-1:0]];
        else if (bus_addr == CTRL_OFF) bus_rdata = {4'b0000, inh_q, 1'b0, h24_q, run_q};
        else                           bus_rdata = 8'h00;
        xfer_busy = copy;
    end

    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && !bus_wr) |=> $stable(sh_flat));

    p_ignore_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!inh_q && st != ST_XFER) |=> $stable(sh_flat));

    p_commit_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (dirty_q == '0));

    p_stopped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !commit) |=> $stable(cnt));

endmodule

// File: tb/sim_rtc_regfile.sv
`timescale 1ns/1ps
module sim_rtc_regfile;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       busy;
    int         vecs = 0;
    int         errs = 0;

    always #2 clk = ~clk;

    rtc_regfile u0 (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .xfer_busy(busy)
    );

    // behavioural model: binary calendar, BCD shadow bank
    int         m_cnt [8];
    logic [7:0] m_sh  [8];
    bit         m_dirty [8];
    logic [7:0] m_ctrl;
    int         m_st;      // 0 live, 1 refresh, 2 frozen, 3 commit
    bit         m_pend;

    function automatic logic [7:0] to_bcd(int v);
        return 8'(((v / 10) << 4) + (v % 10));
    endfunction

    function automatic int from_bcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int days_in(int mon, int fy);
        bit leap;
        leap = ((fy % 4 == 0) && (fy % 100 != 0)) || (fy % 400 == 0);
        if (mon == 2) return leap ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_cnt = '{0, 0, 0, 1, 1, 1, 0, 20};
        for (int i = 0; i < 8; i++) begin
            m_sh[i] = to_bcd(m_cnt[i]);
            m_dirty[i] = 0;
        end
        m_ctrl = 8'h03;
        m_st = 0;
        m_pend = 0;
    endtask

    task automatic model_tick();
        m_cnt[0]++;
        if (m_cnt[0] < 60) return;
        m_cnt[0] = 0; m_cnt[1]++;
        if (m_cnt[1] < 60) return;
        m_cnt[1] = 0; m_cnt[2]++;
        if (m_cnt[2] < 24) return;
        m_cnt[2] = 0;
        m_cnt[3] = (m_cnt[3] == 7) ? 1 : m_cnt[3] + 1;
        m_cnt[4]++;
        if (m_cnt[4] <= days_in(m_cnt[5], m_cnt[7] * 100 + m_cnt[6])) return;
        m_cnt[4] = 1; m_cnt[5]++;
        if (m_cnt[5] <= 12) return;
        m_cnt[5] = 1; m_cnt[6]++;
        if (m_cnt[6] < 100) return;
        m_cnt[6] = 0;
        m_cnt[7] = (m_cnt[7] == 99) ? 0 : m_cnt[7] + 1;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        bit inh, req, go, npend;
        int nst;
        logic [7:0] nsh [8];
        if (!rst_n) begin
            model_reset();
        end else begin
            inh = m_ctrl[3];
            req = tick | m_pend;
            if (m_st == 3) begin npend = req; go = 0; end
            else begin npend = 0; go = req & m_ctrl[0]; end
            nsh = m_sh;
            for (int i = 0; i < 8; i++)
                if (m_st == 1 && !m_dirty[i]) nsh[i] = to_bcd(m_cnt[i]);
            if (m_st == 3) begin
                for (int i = 0; i < 8; i++) begin
                    if (m_dirty[i]) m_cnt[i] = from_bcd(m_sh[i]);
                    m_dirty[i] = 0;
                end
            end else if (go) model_tick();
            if (wr && addr < 4'd8 && inh) begin
                nsh[addr[2:0]] = wdata;
                m_dirty[addr[2:0]] = 1;
            end
            case (m_st)
                0:       nst = go ? 1 : (inh ? 2 : 0);
                1:       nst = inh ? 2 : 0;
                2:       nst = inh ? 2 : 3;
                default: nst = 0;
            endcase
            if (wr && addr == 4'hE) m_ctrl = wdata & 8'h0B;
            m_st = nst;
            m_sh = nsh;
            m_pend = npend;
        end
    end

    function automatic logic [7:0] model_read(logic [3:0] a);
        if (a < 4'd8) return m_sh[a[2:0]];
        if (a == 4'hE) return m_ctrl;
        return 8'h00;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R12 busy", {7'd0, busy}, {7'd0, m_st == 1});
            chk("R2 rdata", rdata, model_read(addr));
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wreg(logic [3:0] a, logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        cyc();
        wr = 1'b0;
    endtask

    task automatic pulse();
        tick = 1'b1;
        cyc();
        tick = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, string req, logic [7:0] exp);
        addr = a;
        @(negedge clk);
        chk(req, rdata, exp);
        #1;
    endtask

    task automatic set_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] wd,
                            logic [7:0] d, logic [7:0] mo, logic [7:0] y, logic [7:0] c);
        wreg(4'hE, 8'h0B);
        wreg(4'h0, s);  wreg(4'h1, mi); wreg(4'h2, h); wreg(4'h3, wd);
        wreg(4'h4, d);  wreg(4'h5, mo); wreg(4'h6, y); wreg(4'h7, c);
        wreg(4'hE, 8'h03);
        cyc(4);
    endtask

    task automatic date_case(logic [7:0] d, logic [7:0] mo, logic [7:0] y, logic [7:0] c,
                             logic [7:0] ed, logic [7:0] emo, string req);
        set_time(8'h59, 8'h59, 8'h23, 8'h03, d, mo, y, c);
        pulse();
        cyc(2);
        rd(4'h4, req, ed);
        rd(4'h5, req, emo);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        errs++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc();
        // R1 reset state, R2 map
        rd(4'h0, "R1 sec", 8'h00);
        rd(4'h3, "R1 weekday", 8'h01);
        rd(4'h5, "R1 month", 8'h01);
        rd(4'h7, "R1 century", 8'h20);
        rd(4'hE, "R1 ctrl", 8'h03);
        rd(4'h9, "R2 unmapped", 8'h00);
        chk("R1 busy", {7'd0, busy}, 8'h00);
        // R3 one tick
        pulse();
        cyc(2);
        rd(4'h0, "R3 sec after tick", 8'h01);
        // R4 R6 full rollover
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h20);
        pulse();
        cyc(2);
        rd(4'h0, "R4 sec", 8'h00);
        rd(4'h1, "R4 min", 8'h00);
        rd(4'h2, "R4 hour", 8'h00);
        rd(4'h3, "R4 weekday", 8'h01);
        rd(4'h4, "R6 date", 8'h01);
        rd(4'h5, "R6 month", 8'h01);
        rd(4'h6, "R6 year", 8'h00);
        rd(4'h7, "R6 century", 8'h21);
        // R8 write with inhibit clear is ignored
        wreg(4'h0, 8'h45);
        cyc(3);
        rd(4'h0, "R8 sec unchanged", 8'h00);
        // R7 freeze while counter runs
        wreg(4'hE, 8'h0B);
        cyc(2);
        pulse(); cyc(2);
        pulse(); cyc(2);
        rd(4'h0, "R7 frozen sec", 8'h00);
        wreg(4'hE, 8'h03);
        cyc(4);
        pulse(); cyc(2);
        rd(4'h0, "R7 counter kept running", 8'h03);
        // R9 partial commit
        wreg(4'hE, 8'h0B);
        wreg(4'h1, 8'h30);
        cyc(2);
        rd(4'h1, "R9 written value visible", 8'h30);
        pulse(); cyc(2);
        wreg(4'hE, 8'h03);
        cyc(4);
        pulse(); cyc(2);
        rd(4'h1, "R9 min loaded", 8'h30);
        rd(4'h0, "R9 sec kept counting", 8'h05);
        rd(4'h2, "R9 hour untouched", 8'h00);
        // R10 inhibit in the tick cycle
        tick = 1'b1; wr = 1'b1; addr = 4'hE; wdata = 8'h0B;
        cyc();
        tick = 1'b0; wr = 1'b0;
        cyc(3);
        rd(4'h0, "R10 refresh completed", 8'h06);
        pulse(); cyc(2);
        rd(4'h0, "R10 then frozen", 8'h06);
        // R13 tick in commit cycle is deferred
        wreg(4'hE, 8'h03);
        cyc();
        pulse();
        cyc(3);
        rd(4'h0, "R13 deferred tick", 8'h08);
        // R11 stop
        wreg(4'hE, 8'h02);
        rd(4'hE, "R2 ctrl readback", 8'h02);
        pulse(); cyc(2);
        pulse(); cyc(2);
        rd(4'h0, "R11 stopped", 8'h08);
        wreg(4'hE, 8'h03);
        cyc(2);
        // R5 month lengths and leap years
        date_case(8'h28, 8'h02, 8'h24, 8'h20, 8'h29, 8'h02, "R5 leap 2024");
        date_case(8'h28, 8'h02, 8'h23, 8'h20, 8'h01, 8'h03, "R5 common 2023");
        date_case(8'h28, 8'h02, 8'h00, 8'h21, 8'h01, 8'h03, "R5 century 2100");
        date_case(8'h28, 8'h02, 8'h00, 8'h20, 8'h29, 8'h02, "R5 century 2000");
        date_case(8'h29, 8'h02, 8'h00, 8'h20, 8'h01, 8'h03, "R5 leap wrap 2000");
        date_case(8'h30, 8'h04, 8'h23, 8'h20, 8'h01, 8'h05, "R5 april");
        date_case(8'h30, 8'h05, 8'h23, 8'h20, 8'h31, 8'h05, "R5 may");
        cyc(2);
        finish_run();
    end

endmodule